// File: doc/BRIEF.md
# Prefix Relocation and Storage-Key Update Unit

This unit sits between the address generation of a processor core and its memory system. It takes a real address and turns it into an absolute address through a per-core prefix value. The lowest 8 KiB of real storage and the 8 KiB block that the prefix selects swap places. Real addresses below 8 KiB land in the prefix block. Real addresses inside the prefix block land at absolute zero. All other addresses pass through unchanged. When the core runs in its narrow addressing mode, the incoming address is first cut to 31 bits.

Each valid access within installed memory also updates the storage key of its 4 KiB page. The key RAM sits outside the unit and holds one 8-bit key per page. The update is a read-modify-write that spans two cycles. The key address is presented in the request cycle, and the merged key is written back in the response cycle. A read permission sets the reference bit and a write permission sets the change bit. A small forwarding register makes sure that back-to-back accesses to the same page lose no bit.

An absolute address above installed memory plus the device window raises an addressing exception.

Top module: `prefix_key_unit`

## Requirements
- R1: After reset, `rspValid` and `keyWrEn` are low until a request is accepted.
- R2: With `reqWide` low, bits 63..31 of `reqAddr` are treated as zero before relocation. With `reqWide` high, the full address is used.
- R3: A masked address below 0x2000 yields absolute address = aligned prefix + address.
- R4: A masked address from the aligned prefix up to aligned prefix + 0x1FFF yields absolute address = address - aligned prefix. When the prefix is zero, the rule of R3 takes precedence, which gives the identity.
- R5: Any other masked address is passed through unchanged as the absolute address.
- R6: Bits 12..0 of `prefixReg` are ignored, so the prefix is always 8 KiB aligned.
- R7: For an access that updates a key, the key at page index absolute[19:12] is written with its old value OR'ed with bit 2 (reference) when `reqRead` is set and bit 1 (change) when `reqWrite` is set. All other key bits are kept.
- R8: A key is written only when the absolute address is at most `memSize`, its page lies inside the key RAM (KEY_PAGES pages), and at least one permission is set. Otherwise `keyWrEn` stays low.
- R9: `rspExc` is high when the absolute address exceeds `memSize + devWindow`. An excepted access never writes a key.
- R10: Back-to-back accesses to the same page accumulate all their key bits, and accesses to different pages do not disturb each other.
- R11: `keyRdAddr` shows the page of the current request in the same cycle. `rspValid`, `rspAddr`, `rspExc` and the key write come out in the cycle after the request, and the key RAM takes the write on the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present this cycle |
| reqAddr | input | ADDR_W | Real address of the access |
| reqRead | input | 1 | Access carries read permission |
| reqWrite | input | 1 | Access carries write permission |
| reqWide | input | 1 | 64-bit addressing mode; low selects 31-bit masking |
| prefixReg | input | ADDR_W | Prefix value, low 13 bits ignored |
| memSize | input | ADDR_W | Highest absolute address of installed memory |
| devWindow | input | ADDR_W | Size of the device window above memory |
| rspValid | output | 1 | Response valid, one cycle after a request |
| rspAddr | output | ADDR_W | Absolute address |
| rspExc | output | 1 | Addressing exception |
| keyRdAddr | output | KEY_AW | Key RAM read address (combinational) |
| keyRdData | input | KEY_W | Key RAM read data, one cycle after the address |
| keyWrEn | output | 1 | Key RAM write enable |
| keyWrAddr | output | KEY_AW | Key RAM write address |
| keyWrData | output | KEY_W | Merged key value |

## Verification
The read address is due in the same cycle as the request, so the bench checks it a moment after driving the inputs at the falling edge. The response, the exception flag and the key-write strobe are due one rising edge later, so the bench checks them at the next falling edge. The key RAM model takes the write on the rising edge after that, so the stored key is read back one further falling edge later. The back-to-back cases issue a request every cycle and check each response in its own cycle. This exposes any loss on the path where the RAM still returns the old key.

// File: rtl/prefix_key_pkg.sv
package prefix_key_pkg;

  // log2 of the swapped low window (8 KiB)
  localparam int WIN_SHIFT = 13;
  // log2 of the storage-key page size (4 KiB)
  localparam int PAGE_SHIFT = 12;
  // key bit set by an access with read permission
  localparam int REF_POS = 2;
  // key bit set by an access with write permission
  localparam int CHG_POS = 1;

  typedef struct packed {
    logic captureReq;   // load the stage registers from the request
    logic stageLive;    // stage registers hold a valid access
    logic commitKey;    // write the merged key this cycle
    logic forwardLive;  // forwarding register holds last cycle's write
  } pkStrobes_t;

endpackage

// File: rtl/pk_control.sv
module pk_control
  import prefix_key_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       stageKeyable,
  output pkStrobes_t strobes,
  output logic       rspValid
);

  logic stageValid;
  logic fwdValid;
  logic commitNow;

  assign commitNow = stageValid & stageKeyable;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      fwdValid   <= 1'b0;
    end else begin
      stageValid <= reqValid;
      fwdValid   <= commitNow;
    end
  end

  always_comb begin
    strobes.captureReq  = reqValid;
    strobes.stageLive   = stageValid;
    strobes.commitKey   = commitNow;
    strobes.forwardLive = fwdValid;
  end

  assign rspValid = stageValid;

endmodule

// File: rtl/pk_datapath.sv
module pk_datapath
  import prefix_key_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int KEY_W     = 8,
  parameter int KEY_PAGES = 256,
  parameter int KEY_AW    = $clog2(KEY_PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pkStrobes_t        strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqRead,
  input  logic              reqWrite,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] prefixReg,
  input  logic [ADDR_W-1:0] memSize,
  input  logic [ADDR_W-1:0] devWindow,
  output logic              stageKeyable,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              rspExc,
  output logic [KEY_AW-1:0] keyRdAddr,
  input  logic [KEY_W-1:0]  keyRdData,
  output logic              keyWrEn,
  output logic [KEY_AW-1:0] keyWrAddr,
  output logic [KEY_W-1:0]  keyWrData
);

  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
  localparam logic [ADDR_W-1:0] NARROW_MASK = ADDR_W'(32'h7fff_ffff);
  localparam logic [ADDR_W-1:0] WIN_MASK    = ADDR_W'((1 << WIN_SHIFT) - 1);
  localparam logic [PAGE_W-1:0] PAGE_LIMIT  = PAGE_W'(KEY_PAGES);

  // ---------------- request-cycle relocation ----------------
  logic [ADDR_W-1:0] maskedAddr;
  logic [ADDR_W-1:0] basePrefix;
  logic [ADDR_W-1:0] absAddr;
  logic              hitLow;
  logic              hitPrefix;
  logic [ADDR_W:0]   limitSum;
  logic              overLimit;
  logic              withinMem;
  logic              pageFits;

  assign maskedAddr = reqWide ? reqAddr : (reqAddr & NARROW_MASK);
  assign basePrefix = prefixReg & ~WIN_MASK;
  assign hitLow     = (maskedAddr & ~WIN_MASK) == '0;
  assign hitPrefix  = (maskedAddr & ~WIN_MASK) == basePrefix;

  // low window wins, so a zero prefix gives the identity
  always_comb begin
    if (hitLow) begin
      absAddr = basePrefix | (maskedAddr & WIN_MASK);
    end else if (hitPrefix) begin
      absAddr = maskedAddr & WIN_MASK;
    end else begin
      absAddr = maskedAddr;
    end
  end

  assign limitSum  = {1'b0, memSize} + {1'b0, devWindow};
  assign overLimit = {1'b0, absAddr} > limitSum;
  assign withinMem = absAddr <= memSize;
  assign pageFits  = absAddr[ADDR_W-1:PAGE_SHIFT] < PAGE_LIMIT;
  assign keyRdAddr = absAddr[PAGE_SHIFT +: KEY_AW];

  // ---------------- stage registers ----------------
  logic [ADDR_W-1:0] stageAbs;
  logic              stageRd;
  logic              stageWr;
  logic              stageExc;
  logic              stageKeyOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageAbs   <= '0;
      stageRd    <= 1'b0;
      stageWr    <= 1'b0;
      stageExc   <= 1'b0;
      stageKeyOk <= 1'b0;
    end else if (strobes.captureReq) begin
      stageAbs   <= absAddr;
      stageRd    <= reqRead;
      stageWr    <= reqWrite;
      stageExc   <= overLimit;
      stageKeyOk <= withinMem & pageFits & ~overLimit;
    end
  end

  assign stageKeyable = stageKeyOk & (stageRd | stageWr);

  // ---------------- key merge with forwarding ----------------
  logic [KEY_AW-1:0] stagePage;
  logic [KEY_AW-1:0] fwdPage;
  logic [KEY_W-1:0]  fwdKey;
  logic [KEY_W-1:0]  mergeBase;
  logic [KEY_W-1:0]  setBits;
  logic              fwdHit;

  assign stagePage = stageAbs[PAGE_SHIFT +: KEY_AW];
  assign fwdHit    = strobes.forwardLive && (fwdPage == stagePage);
  assign mergeBase = fwdHit ? fwdKey : keyRdData;
  assign setBits   = (KEY_W'(stageRd) << REF_POS) | (KEY_W'(stageWr) << CHG_POS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdPage <= '0;
      fwdKey  <= '0;
    end else if (strobes.commitKey) begin
      fwdPage <= stagePage;
      fwdKey  <= mergeBase | setBits;
    end
  end

  assign keyWrEn   = strobes.commitKey;
  assign keyWrAddr = stagePage;
  assign keyWrData = mergeBase | setBits;
  assign rspAddr   = stageAbs;
  assign rspExc    = strobes.stageLive & stageExc;

endmodule

// File: rtl/prefix_key_unit.sv
module prefix_key_unit
  import prefix_key_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int KEY_W     = 8,
  parameter int KEY_PAGES = 256,
  localparam int KEY_AW   = $clog2(KEY_PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqRead,
  input  logic              reqWrite,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] prefixReg,
  input  logic [ADDR_W-1:0] memSize,
  input  logic [ADDR_W-1:0] devWindow,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              rspExc,
  output logic [KEY_AW-1:0] keyRdAddr,
  input  logic [KEY_W-1:0]  keyRdData,
  output logic              keyWrEn,
  output logic [KEY_AW-1:0] keyWrAddr,
  output logic [KEY_W-1:0]  keyWrData
);

  pkStrobes_t strobes;
  logic       stageKeyable;

  pk_control ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .stageKeyable (stageKeyable),
    .strobes      (strobes),
    .rspValid     (rspValid)
  );

  pk_datapath #(
    .ADDR_W    (ADDR_W),
    .KEY_W     (KEY_W),
    .KEY_PAGES (KEY_PAGES),
    .KEY_AW    (KEY_AW)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .reqAddr      (reqAddr),
    .reqRead      (reqRead),
    .reqWrite     (reqWrite),
    .reqWide      (reqWide),
    .prefixReg    (prefixReg),
    .memSize      (memSize),
    .devWindow    (devWindow),
    .stageKeyable (stageKeyable),
    .rspAddr      (rspAddr),
    .rspExc       (rspExc),
    .keyRdAddr    (keyRdAddr),
    .keyRdData    (keyRdData),
    .keyWrEn      (keyWrEn),
    .keyWrAddr    (keyWrAddr),
    .keyWrData    (keyWrData)
  );

endmodule

// File: rtl/pk_checker.sv
module pk_checker
  import prefix_key_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int KEY_W  = 8,
  parameter int KEY_AW = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqRead,
  input logic              reqWrite,
  input logic              reqWide,
  input logic [ADDR_W-1:0] prefixReg,
  input logic [ADDR_W-1:0] memSize,
  input logic              rspValid,
  input logic [ADDR_W-1:0] rspAddr,
  input logic              rspExc,
  input logic              keyWrEn,
  input logic [KEY_W-1:0]  keyWrData
);

  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << WIN_SHIFT) - 1);

  AST_KEY_NEEDS_RESPONSE: assert property (@(posedge clk) disable iff (!rstN)
    keyWrEn |-> rspValid); // R11

  AST_EXC_NO_KEY: assert property (@(posedge clk) disable iff (!rstN)
    keyWrEn |-> !rspExc); // R9

  AST_KEY_IN_MEMORY: assert property (@(posedge clk) disable iff (!rstN)
    keyWrEn |-> (rspAddr <= $past(memSize))); // R8

  AST_READ_SETS_REF: assert property (@(posedge clk) disable iff (!rstN)
    (keyWrEn && $past(reqRead)) |-> keyWrData[REF_POS]); // R7

  AST_WRITE_SETS_CHG: assert property (@(posedge clk) disable iff (!rstN)
    (keyWrEn && $past(reqWrite)) |-> keyWrData[CHG_POS]); // R7

  AST_LOW_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(reqValid && reqWide && ((reqAddr & ~LOW_MASK) == '0)))
      |-> (rspAddr == ($past(reqAddr) | ($past(prefixReg) & ~LOW_MASK)))); // R3

endmodule

bind prefix_key_unit pk_checker #(
  .ADDR_W (ADDR_W),
  .KEY_W  (KEY_W),
  .KEY_AW (KEY_AW)
) checker_i (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqAddr   (reqAddr),
  .reqRead   (reqRead),
  .reqWrite  (reqWrite),
  .reqWide   (reqWide),
  .prefixReg (prefixReg),
  .memSize   (memSize),
  .rspValid  (rspValid),
  .rspAddr   (rspAddr),
  .rspExc    (rspExc),
  .keyWrEn   (keyWrEn),
  .keyWrData (keyWrData)
);

// File: tb/prefix_key_unit_test.sv
`timescale 1ns/1ps
module prefix_key_unit_test;

  localparam int ADDR_W = 64;
  localparam int KEY_W  = 8;
  localparam int PAGES  = 256;
  localparam int KAW    = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqRead = 1'b0;
  logic              reqWrite = 1'b0;
  logic              reqWide = 1'b1;
  logic [ADDR_W-1:0] prefixReg = 64'h1_0000;
  logic [ADDR_W-1:0] memSize = 64'h0F_FFFF;
  logic [ADDR_W-1:0] devWindow = 64'h1_0000;
  logic              rspValid;
  logic [ADDR_W-1:0] rspAddr;
  logic              rspExc;
  logic [KAW-1:0]    keyRdAddr;
  logic [KEY_W-1:0]  keyRdData;
  logic              keyWrEn;
  logic [KAW-1:0]    keyWrAddr;
  logic [KEY_W-1:0]  keyWrData;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  prefix_key_unit #(.ADDR_W(ADDR_W), .KEY_W(KEY_W), .KEY_PAGES(PAGES)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqRead(reqRead), .reqWrite(reqWrite), .reqWide(reqWide),
    .prefixReg(prefixReg), .memSize(memSize), .devWindow(devWindow),
    .rspValid(rspValid), .rspAddr(rspAddr), .rspExc(rspExc),
    .keyRdAddr(keyRdAddr), .keyRdData(keyRdData), .keyWrEn(keyWrEn),
    .keyWrAddr(keyWrAddr), .keyWrData(keyWrData)
  );

  // key RAM model: one-cycle read, old data on same-edge write
  logic [KEY_W-1:0] keyMem [PAGES];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PAGES; i++) keyMem[i] <= 8'h10;
      keyRdData <= '0;
    end else begin
      keyRdData <= keyMem[keyRdAddr];
      if (keyWrEn) keyMem[keyWrAddr] <= keyWrData;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] addr, input logic rd, input logic wr,
                       input logic wide);
    reqValid = 1'b1;
    reqAddr  = addr;
    reqRead  = rd;
    reqWrite = wr;
    reqWide  = wide;
  endtask

  // check response fields in the cycle after the request
  task automatic checkRsp(input logic [63:0] expAbs, input logic expExc,
                          input logic expKey, input string tag);
    chk(rspValid == 1'b1, {tag, " R11 rspValid"}, 64'(rspValid), 64'd1);
    chk(rspAddr == expAbs, {tag, " rspAddr"}, rspAddr, expAbs);
    chk(rspExc == expExc, {tag, " R9 rspExc"}, 64'(rspExc), 64'(expExc));
    chk(keyWrEn == expKey, {tag, " R8 keyWrEn"}, 64'(keyWrEn), 64'(expKey));
  endtask

  // single access: request, response, then stored key
  task automatic access(input logic [63:0] addr, input logic rd, input logic wr,
                        input logic wide, input logic [63:0] expAbs,
                        input logic expExc, input logic expKey,
                        input logic [7:0] expStored, input string tag);
    drive(addr, rd, wr, wide);
    #1;
    if (expKey) chk(keyRdAddr == expAbs[19:12], {tag, " R11 keyRdAddr"},
                    64'(keyRdAddr), 64'(expAbs[19:12]));
    @(negedge clk);
    reqValid = 1'b0;
    checkRsp(expAbs, expExc, expKey, tag);
    @(negedge clk);
    if (expKey) chk(keyMem[expAbs[19:12]] == expStored, {tag, " R7 stored key"},
                    64'(keyMem[expAbs[19:12]]), 64'(expStored));
  endtask

  task automatic testReset();
    chk(rspValid == 1'b0, "R1 rspValid after reset", 64'(rspValid), 64'd0);
    chk(keyWrEn == 1'b0, "R1 keyWrEn after reset", 64'(keyWrEn), 64'd0);
  endtask

  task automatic testMask();
    // R2: narrow mode drops high bits, result 0x3000 passes through (R5)
    access(64'hFFFF_FFFF_8000_3000, 1, 0, 0, 64'h3000, 0, 1, 8'h14, "R2 narrow");
    // R2: wide mode keeps them, far above memory -> exception
    access(64'h0000_0000_8000_3000, 1, 0, 1, 64'h8000_3000, 1, 0, 8'h00, "R2 wide");
  endtask

  task automatic testWindows();
    access(64'h1234, 1, 0, 1, 64'h1_1234, 0, 1, 8'h14, "R3 low window");
    access(64'h1_1ABC, 0, 1, 1, 64'h1ABC, 0, 1, 8'h12, "R4 prefix area");
    access(64'h5_0040, 0, 1, 1, 64'h5_0040, 0, 1, 8'h12, "R5 pass through");
  endtask

  task automatic testUnaligned();
    prefixReg = 64'h1_1FFF;
    access(64'h0100, 1, 0, 1, 64'h1_0100, 0, 1, 8'h14, "R6 low window");
    access(64'h1_0800, 0, 1, 1, 64'h0800, 0, 1, 8'h12, "R6 prefix area");
    prefixReg = 64'h0;
    // page 1 already holds 0x12 from the R4 case
    access(64'h1000, 1, 0, 1, 64'h1000, 0, 1, 8'h16, "R4 zero prefix");
    prefixReg = 64'h1_0000;
  endtask

  task automatic testLimits();
    access(64'h10_0800, 1, 0, 1, 64'h10_0800, 0, 0, 8'h00, "R8 device window");
    access(64'h10_FFFF, 1, 1, 1, 64'h10_FFFF, 0, 0, 8'h00, "R9 at limit");
    access(64'h11_0000, 1, 1, 1, 64'h11_0000, 1, 0, 8'h00, "R9 over limit");
    // no permission: no key write
    access(64'h4_0000, 0, 0, 1, 64'h4_0000, 0, 0, 8'h00, "R8 no permission");
    chk(keyMem[8'h40] == 8'h10, "R8 untouched key", 64'(keyMem[8'h40]), 64'h10);
  endtask

  task automatic testBackToBack();
    // same page, read then write in consecutive cycles
    drive(64'h2_0010, 1, 0, 1);
    @(negedge clk);
    checkRsp(64'h2_0010, 0, 1, "R10 first");
    drive(64'h2_0020, 0, 1, 1);
    @(negedge clk);
    checkRsp(64'h2_0020, 0, 1, "R10 second");
    // three in a row on page 0x21
    drive(64'h2_1000, 1, 0, 1);
    @(negedge clk);
    drive(64'h2_1004, 0, 1, 1);
    @(negedge clk);
    drive(64'h2_1008, 1, 0, 1);
    @(negedge clk);
    // different pages back to back
    drive(64'h3_0000, 0, 1, 1);
    @(negedge clk);
    drive(64'h3_1000, 1, 0, 1);
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(keyMem[8'h20] == 8'h16, "R10 page 0x20", 64'(keyMem[8'h20]), 64'h16);
    chk(keyMem[8'h21] == 8'h16, "R10 page 0x21", 64'(keyMem[8'h21]), 64'h16);
    chk(keyMem[8'h30] == 8'h12, "R10 page 0x30", 64'(keyMem[8'h30]), 64'h12);
    chk(keyMem[8'h31] == 8'h14, "R10 page 0x31", 64'(keyMem[8'h31]), 64'h14);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMask();
    testWindows();
    testUnaligned();
    testLimits();
    testBackToBack();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule